// File: doc/BRIEF.md
# Baud Tick and Clock-Out Generator

This block is a 16-bit reload counter used as a rate source. When either serial direction selects it, the counter advances once every two oscillator clocks. On every wrap past all-ones it reloads a preset value. Each wrap gives a one-cycle tick to the transmit side, the receive side, or both, depending on which directions select it. A square-wave output can also be enabled. It toggles on each wrap, so it gives a 50% duty-cycle clock from the same preset value.

When neither direction nor the clock output uses the counter, it behaves as a plain auto-reload timer. It then advances once every twelve clocks and raises an overflow flag on each wrap. The counter can instead be driven by falling edges of a count pin.

An external input with an enable acts as an extra event source: a falling edge sets an event flag. In plain timer mode that edge also reloads the counter, but in rate mode it does not. The counter and the reload value can be written only while the counter is stopped.

Top module: `rate_clkout_gen`

## Requirements
- R1: After reset, count_val is 0 and tx_tick, rx_tick, clk_out, ovf_flag and ext_flag are all 0.
- R2: While run=1 and cnt_sel=0, the counter advances once every 2 clocks when tx_sel, rx_sel or (out_en and not cnt_sel) is 1, and once every 12 clocks otherwise. While run=0 the counter does not advance.
- R3: An advance from the all-ones value loads the reload value into the counter; any other advance adds one.
- R4: Each wrap gives a one-cycle pulse on tx_tick, in the clock after the wrap, when tx_sel=1, and on rx_tick when rx_sel=1. Neither tick pulses for a direction whose select is 0.
- R5: A wrap sets ovf_flag only when tx_sel=0, rx_sel=0 and clock-out is not enabled. ovf_clr clears the flag, and a set in the same cycle wins over the clear.
- R6: With ext_en=1, a 1-to-0 transition on ext_in sets ext_flag, and ext_clr clears it (a set wins). With tx_sel or rx_sel set, the edge does not change the counter.
- R7: With tx_sel=0 and rx_sel=0, an ext_in falling edge with ext_en=1 loads the reload value into the counter, whether or not run is set.
- R8: With out_en=1 and cnt_sel=0, clk_out toggles on every wrap. With default parameters this gives a period of 4*(65536-reload) clocks. Otherwise clk_out is held at 0.
- R9: A wr_count or wr_reload pulse loads wr_data while run=0 and is ignored while run=1.
- R10: With cnt_sel=1 and run=1, the counter advances once per 1-to-0 transition on cnt_pin instead of on the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter run enable |
| tx_sel | input | 1 | Use the counter as the transmit rate source |
| rx_sel | input | 1 | Use the counter as the receive rate source |
| cnt_sel | input | 1 | 1: count cnt_pin falling edges, 0: count the prescaler |
| out_en | input | 1 | Clock-output enable |
| cnt_pin | input | 1 | External count input |
| ext_in | input | 1 | External event input |
| ext_en | input | 1 | Enables ext_in edge detection |
| wr_count | input | 1 | Write wr_data to the counter |
| wr_reload | input | 1 | Write wr_data to the reload value |
| wr_data | input | CNT_W | Write data |
| ovf_clr | input | 1 | Clear ovf_flag |
| ext_clr | input | 1 | Clear ext_flag |
| tx_tick | output | 1 | Transmit rate tick |
| rx_tick | output | 1 | Receive rate tick |
| clk_out | output | 1 | 50% duty-cycle clock output |
| ovf_flag | output | 1 | Plain-timer overflow flag |
| ext_flag | output | 1 | External event flag |
| count_val | output | CNT_W | Current counter value |

## Verification
The bench uses the default parameters: a 16-bit counter, a fast divide of 2 and a slow divide of 12. It writes reload and start values a few steps below all-ones, so wraps, ticks, clock-out toggles and overflow flags occur within tens of cycles in every mode. A behavioural model is compared against every output on every clock. The model covers rate mode, receive-only mode, the slow plain timer, pin counting, and ignored writes while running. It also covers falling edges on the external input in both rate mode and plain mode.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  typedef struct packed {
    logic rate;    // counter feeds a serial direction
    logic clk_en;  // clock output active
    logic fast;    // prescaler uses the fast divide
  } rcg_mode_t;

  function automatic rcg_mode_t rcg_decode(input logic tx_sel, input logic rx_sel,
                                           input logic out_en, input logic cnt_sel);
    rcg_mode_t m;
    m.rate   = tx_sel | rx_sel;
    m.clk_en = out_en & ~cnt_sel;
    m.fast   = m.rate | m.clk_en;
    return m;
  endfunction
endpackage

// File: rtl/rcg_fall.sv
module rcg_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign fall = prev_q & ~din;
endmodule

// File: rtl/rcg_prescale.sv
module rcg_prescale #(
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int PW = (SLOW_DIV > FAST_DIV) ? $clog2(SLOW_DIV) : $clog2(FAST_DIV);
  localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
  localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);

  logic [PW-1:0] pcnt_q, pcnt_nx, lim;

  assign lim  = fast ? FAST_LIM : SLOW_LIM;
  assign tick = run && (pcnt_q >= lim);

  always_comb begin
    pcnt_nx = pcnt_q;
    if (!run)               pcnt_nx = '0;
    else if (pcnt_q >= lim) pcnt_nx = '0;
    else                    pcnt_nx = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_nx;
  end

  // R2: ticks never come on consecutive clocks
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rcg_count.sv
module rcg_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic             ext_rld,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             roll
);
  logic [CNT_W-1:0] cnt_q, cnt_nx, rld_q, rld_nx;
  logic             at_max, wr_cnt_ok, wr_rld_ok;

  assign at_max    = (cnt_q == {CNT_W{1'b1}});
  assign wr_cnt_ok = wr_count & ~run;
  assign wr_rld_ok = wr_reload & ~run;
  assign roll      = adv & at_max;
  assign count     = cnt_q;

  always_comb begin
    cnt_nx = cnt_q;
    rld_nx = rld_q;
    if (wr_cnt_ok)    cnt_nx = wr_data;
    else if (ext_rld) cnt_nx = rld_q;
    else if (adv)     cnt_nx = at_max ? rld_q : cnt_q + 1'b1;
    if (wr_rld_ok)    rld_nx = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      rld_q <= rld_nx;
    end
  end

  // R9: a counter write while running leaves the count alone
  assert_run_blocks_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_count && !adv && !ext_rld) |=> (cnt_q == $past(cnt_q)));
  // R3: wrapping loads the preset value
  assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_max && !ext_rld) |=> (cnt_q == $past(rld_q)));
endmodule

// File: rtl/rcg_flags.sv
module rcg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic roll,
  input  logic rate,
  input  logic clk_en,
  input  logic tx_sel,
  input  logic rx_sel,
  input  logic ext_set,
  input  logic ovf_clr,
  input  logic ext_clr,
  output logic tx_tick,
  output logic rx_tick,
  output logic clk_out,
  output logic ovf_flag,
  output logic ext_flag
);
  logic tx_q, rx_q, clk_q, ovf_q, ext_q;
  logic tx_nx, rx_nx, clk_nx, ovf_nx, ext_nx;

  always_comb begin
    tx_nx  = roll & tx_sel;
    rx_nx  = roll & rx_sel;
    ovf_nx = ovf_q;
    if (ovf_clr) ovf_nx = 1'b0;
    if (roll && !rate && !clk_en) ovf_nx = 1'b1;
    ext_nx = ext_q;
    if (ext_clr) ext_nx = 1'b0;
    if (ext_set) ext_nx = 1'b1;
    if (!clk_en)   clk_nx = 1'b0;
    else if (roll) clk_nx = ~clk_q;
    else           clk_nx = clk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0; rx_q <= 1'b0; clk_q <= 1'b0; ovf_q <= 1'b0; ext_q <= 1'b0;
    end else begin
      tx_q <= tx_nx; rx_q <= rx_nx; clk_q <= clk_nx; ovf_q <= ovf_nx; ext_q <= ext_nx;
    end
  end

  assign tx_tick  = tx_q;
  assign rx_tick  = rx_q;
  assign clk_out  = clk_q;
  assign ovf_flag = ovf_q;
  assign ext_flag = ext_q;

  // R5: wraps in rate or clock-out use never raise the overflow flag
  assert_rate_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && (rate || clk_en) && !ovf_q) |=> !ovf_q);
  // R8: clock output idles low when disabled
  assert_clkout_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !clk_q);
  // R4: a tick lasts one cycle when wraps are spaced by the prescaler
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_q && !roll) |=> !tx_q);
endmodule

// File: rtl/rate_clkout_gen.sv
module rate_clkout_gen
  import rcg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FAST_DIV = 2,
  parameter int SLOW_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tx_sel,
  input  logic             rx_sel,
  input  logic             cnt_sel,
  input  logic             out_en,
  input  logic             cnt_pin,
  input  logic             ext_in,
  input  logic             ext_en,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_clr,
  input  logic             ext_clr,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             clk_out,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic [CNT_W-1:0] count_val
);
  localparam int NEDGE = 2;

  logic      rs1_q, rs2_q, rst_i;
  rcg_mode_t mode;
  logic      ptick, adv, roll, ext_rld, ext_set;
  logic [NEDGE-1:0] edge_in, edge_fall;

  // reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  assign mode = rcg_decode(tx_sel, rx_sel, out_en, cnt_sel);

  assign edge_in = {ext_in, cnt_pin};
  for (genvar g = 0; g < NEDGE; g++) begin : g_fall
    rcg_fall u_fall (.clk(clk), .rst_n(rst_i), .din(edge_in[g]), .fall(edge_fall[g]));
  end

  rcg_prescale #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_i), .run(run), .fast(mode.fast), .tick(ptick));

  assign adv     = run & (cnt_sel ? edge_fall[0] : ptick);
  assign ext_set = ext_en & edge_fall[1];
  assign ext_rld = ext_set & ~mode.rate;

  rcg_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i), .run(run), .adv(adv), .ext_rld(ext_rld),
    .wr_count(wr_count), .wr_reload(wr_reload), .wr_data(wr_data),
    .count(count_val), .roll(roll));

  rcg_flags u_flg (
    .clk(clk), .rst_n(rst_i), .roll(roll), .rate(mode.rate), .clk_en(mode.clk_en),
    .tx_sel(tx_sel), .rx_sel(rx_sel), .ext_set(ext_set), .ovf_clr(ovf_clr),
    .ext_clr(ext_clr), .tx_tick(tx_tick), .rx_tick(rx_tick), .clk_out(clk_out),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag));

  // R6: an external edge in rate mode leaves the count alone
  assert_ext_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (ext_set && mode.rate && !adv && !(wr_count && !run)) |=> $stable(count_val));
  // R2: a stopped counter holds
  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (!run && !wr_count && !ext_rld) |=> $stable(count_val));
endmodule

// File: tb/sim_rate_clkout_gen.sv
module sim_rate_clkout_gen;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, tx_sel = 0, rx_sel = 0, cnt_sel = 0, out_en = 0;
  logic cnt_pin = 0, ext_in = 0, ext_en = 0, wr_count = 0, wr_reload = 0;
  logic ovf_clr = 0, ext_clr = 0;
  logic [W-1:0] wr_data = '0;
  logic tx_tick, rx_tick, clk_out, ovf_flag, ext_flag;
  logic [W-1:0] count_val;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  rate_clkout_gen u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .cnt_sel(cnt_sel), .out_en(out_en), .cnt_pin(cnt_pin), .ext_in(ext_in),
    .ext_en(ext_en), .wr_count(wr_count), .wr_reload(wr_reload), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .ext_clr(ext_clr), .tx_tick(tx_tick), .rx_tick(rx_tick),
    .clk_out(clk_out), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .count_val(count_val));

  // behavioural reference
  int     m_pc = 0, rs = 0;
  int     m_cnt = 0, m_rld = 0;
  bit     m_tx = 0, m_rx = 0, m_clk = 0, m_ovf = 0, m_ext = 0, m_cq = 0, m_eq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; rs = 0; m_cnt = 0; m_rld = 0;
      m_tx = 0; m_rx = 0; m_clk = 0; m_ovf = 0; m_ext = 0; m_cq = 0; m_eq = 0;
    end else if (rs < 2) begin
      rs++;
    end else begin
      bit rate, cen, fast, tick, cfall, efall, adv, roll;
      int div, n_cnt;
      rate  = tx_sel || rx_sel;
      cen   = out_en && !cnt_sel;
      fast  = rate || cen;
      div   = fast ? 2 : 12;
      tick  = run && (m_pc >= div - 1);
      cfall = m_cq && !cnt_pin;
      efall = m_eq && !ext_in;
      adv   = run && (cnt_sel ? cfall : tick);
      roll  = adv && (m_cnt == (1 << W) - 1);
      n_cnt = m_cnt;
      if (!run && wr_count)            n_cnt = wr_data;
      else if (ext_en && efall && !rate) n_cnt = m_rld;
      else if (roll)                   n_cnt = m_rld;
      else if (adv)                    n_cnt = m_cnt + 1;
      if (!run && wr_reload) m_rld = wr_data;
      m_cnt = n_cnt;
      m_pc  = (!run || m_pc >= div - 1) ? 0 : m_pc + 1;
      if (ovf_clr) m_ovf = 0;
      if (roll && !fast) m_ovf = 1;
      if (ext_clr) m_ext = 0;
      if (ext_en && efall) m_ext = 1;
      m_clk = !cen ? 0 : (roll ? !m_clk : m_clk);
      m_tx = roll && tx_sel;
      m_rx = roll && rx_sel;
      m_cq = cnt_pin;
      m_eq = ext_in;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && rs >= 2) begin
      chk("R2 R3 R7 R9 R10 count", count_val, m_cnt);
      chk("R4 tx_tick", tx_tick, m_tx);
      chk("R4 rx_tick", rx_tick, m_rx);
      chk("R8 clk_out", clk_out, m_clk);
      chk("R5 ovf_flag", ovf_flag, m_ovf);
      chk("R6 ext_flag", ext_flag, m_ext);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_regs(input logic [W-1:0] cv, input logic [W-1:0] rv);
    wr_data = rv; wr_reload = 1; wait_n(1);
    wr_reload = 0; wr_data = cv; wr_count = 1; wait_n(1);
    wr_count = 0; wait_n(1);
  endtask

  task automatic ext_fall_pulse();
    ext_in = 1; wait_n(3); ext_in = 0; wait_n(3);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait_n(3);
    // R1: reset state
    chk("R1 count", count_val, 0);
    chk("R1 outputs", {tx_tick, rx_tick, clk_out, ovf_flag, ext_flag}, 0);
    rst_n = 1;
    wait_n(4);
    chk("R1 count after release", count_val, 0);

    // R9: writes accepted while stopped
    write_regs(16'hFFF0, 16'hFFF0);
    chk("R9 write readback", count_val, 16'hFFF0);

    // rate mode, transmit only, with clock output (R2 R3 R4 R8)
    tx_sel = 1; out_en = 1; run = 1;
    wait_n(150);
    // R9: write ignored while running
    wr_data = 16'h0000; wr_count = 1; wr_reload = 1; wait_n(1);
    wr_count = 0; wr_reload = 0;
    wait_n(40);
    // R6: external edge sets flag, no reload in rate mode
    ext_en = 1;
    ext_fall_pulse();
    chk("R6 flag set", ext_flag, 1);
    ext_clr = 1; wait_n(1); ext_clr = 0;
    wait_n(40);

    // receive only, no clock output
    run = 0; wait_n(2);
    tx_sel = 0; rx_sel = 1; out_en = 0;
    write_regs(16'hFFF8, 16'hFFF4);
    run = 1; wait_n(120);

    // plain slow timer: overflow flag and external reload (R5 R7)
    run = 0; wait_n(2);
    rx_sel = 0;
    write_regs(16'hFFFC, 16'hFFFA);
    run = 1; wait_n(150);
    chk("R5 ovf set in plain mode", ovf_flag, 1);
    ovf_clr = 1; wait_n(1); ovf_clr = 0;
    ext_fall_pulse();
    wait_n(30);
    run = 0; wait_n(2);
    ext_fall_pulse();   // R7: reload while stopped
    chk("R7 reload while stopped", count_val, 16'hFFFA);

    // pin counting with clock output requested (R10 R8)
    cnt_sel = 1; out_en = 1;
    write_regs(16'hFFFD, 16'hFFFB);
    run = 1;
    for (int i = 0; i < 20; i++) begin
      cnt_pin = 1; wait_n(2); cnt_pin = 0; wait_n(2);
    end
    chk("R8 clk_out idle in counter mode", clk_out, 0);
    run = 0;
    wait_n(10);
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule